// File: doc/BRIEF.md
# Module Configuration Memory Two-Wire Responder

This block is a two-wire serial slave that answers for the small configuration memory carried on a memory module. The memory holds 256 bytes. The host reads these bytes to learn the module's geometry and timing. The device address is partly fixed and partly taken from three strap inputs, so up to eight modules can share one bus. Each module answers only to its own address. The block oversamples the clock and data lines with the system clock, detects START and STOP, and shifts bytes in and out. It only ever pulls the data line low. It never drives the line high.

A write transaction carries one word-address byte, which loads an internal byte pointer. Any further bytes in the same transaction are stored at the pointer, and the pointer advances after each one. A read transaction returns bytes from the pointer onward, most significant bit first. The read continues for as long as the host acknowledges each byte. A write-protect input blocks stores. Byte 63 is a checksum over bytes 0 to 62. The block recomputes it by itself after every accepted store into that range.

Top module: `spdResponder`

## Requirements
- R1: After reset, byte 0 reads 0x80, byte 1 reads 0x08, byte 2 reads 0x04 and byte 63 reads 0x8C, and the responder does not pull the data line low.
- R2: The 7-bit device address is 1010 followed by strap bit 2, strap bit 1 and strap bit 0. The eighth bit of the address byte is 1 for a read and 0 for a write. On a match, the responder pulls the data line low during the ninth clock.
- R3: An address byte that does not match gets no acknowledge, and the responder ignores the bus until the next START.
- R4: In a write transaction, the first byte after the address is the word address and loads the pointer. Each further byte is acknowledged, stored at the pointer, and advances the pointer by one.
- R5: A read transaction issued after a repeated START returns the byte at the pointer, most significant bit first, driven while the clock is low.
- R6: In a read, a host acknowledge after a byte makes the responder send the next byte. A host not-acknowledge makes it release the line and go idle.
- R7: The pointer wraps from 255 to 0, both on reads and on stores.
- R8: While write-protect is high, the word-address byte is still acknowledged. Data bytes are not acknowledged, and the memory stays unchanged.
- R9: After any accepted store to bytes 0 to 62, byte 63 holds the low 8 bits of the sum of bytes 0 to 62 before the next read can reach it.
- R10: A STOP releases the data line, and the responder then stays idle until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired-AND result) |
| strapIn | input | 3 | Board strap bits that select the low address bits |
| wpIn | input | 1 | Write protect; high blocks stores |
| sdaLow | output | 1 | When high, the open-drain stage pulls the data line low |

## Verification
A wrong controller state shows up as a missing or extra acknowledge within one bit time of the byte that caused it. This holds most clearly for a mismatched address or a protected store. A corrupt pointer or a bad wrap first shows up as a wrong byte on the next read, so every store is followed by a readback of the same addresses. A stale checksum can only be seen by reading byte 63. The bench therefore reads byte 63 after each covered store, including a store that wrapped past byte 255 into byte 0.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_DEVACK, S_RECV, S_RECVACK, S_SEND, S_SENDACK
  } ctrlState_t;

  typedef struct packed {
    logic       setPtr;
    logic       writeByte;
    logic       incPtr;
    logic [7:0] data;
  } spdStrobe_t;

  // Power-up content: defined-length, size code, type code and matching checksum.
  function automatic logic [7:0] initByte(input int idx, input int csumPos);
    if (idx == 0)            return 8'h80;
    else if (idx == 1)       return 8'h08;
    else if (idx == 2)       return 8'h04;
    else if (idx == csumPos) return 8'h8C;
    else                     return 8'h00;
  endfunction

endpackage

// File: rtl/spdStore.sv
module spdStore
  import spd_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int CSUM_POS  = 63,
  localparam int PTR_W    = $clog2(MEM_BYTES)
) (
  input  logic       clk,
  input  logic       rstN,
  input  spdStrobe_t st,
  output logic [7:0] rdByte
);

  logic [7:0]       mem [MEM_BYTES];
  logic [PTR_W-1:0] ptr;
  logic             recalc;
  logic [7:0]       covSum;

  always_comb begin
    covSum = 8'h00;
    for (int i = 0; i < CSUM_POS; i++) covSum = covSum + mem[i];
  end

  assign rdByte = mem[ptr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= initByte(i, CSUM_POS);
      ptr    <= '0;
      recalc <= 1'b0;
    end else begin
      recalc <= 1'b0;
      if (st.setPtr) ptr <= st.data[PTR_W-1:0];
      if (st.incPtr) ptr <= ptr + 1'b1;
      if (recalc) mem[CSUM_POS] <= covSum;
      if (st.writeByte) begin
        mem[ptr] <= st.data;
        ptr      <= ptr + 1'b1;
        recalc   <= (ptr < PTR_W'(CSUM_POS));
      end
    end
  end

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((st.incPtr || st.writeByte) && !st.setPtr && ptr == {PTR_W{1'b1}}) |=> ptr == '0);

  // R9
  csum_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.writeByte && ptr < PTR_W'(CSUM_POS)) |=> ##1 (st.writeByte || mem[CSUM_POS] == covSum));

endmodule

// File: rtl/spdCtrl.sv
module spdCtrl
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapIn,
  input  logic       wpIn,
  input  logic [7:0] rdByte,
  output spdStrobe_t st,
  output logic       sdaLow
);

  localparam logic [3:0] DEV_CODE = 4'b1010;

  logic [2:0] sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet, sdaBit;
  logic [6:0] devAddr;

  ctrlState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shreg, txShift;
  logic       rdMode, gotWord, mastAck;

  assign devAddr  = {DEV_CODE, strapIn};
  assign sdaBit   = sdaS[1];
  assign sclRise  = sclS[1] & ~sclS[2];
  assign sclFall  = ~sclS[1] & sclS[2];
  assign startDet = sclS[1] & sclS[2] & sdaS[2] & ~sdaS[1];
  assign stopDet  = sclS[1] & sclS[2] & ~sdaS[2] & sdaS[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclS <= 3'b111;
      sdaS <= 3'b111;
    end else begin
      sclS <= {sclS[1:0], sclIn};
      sdaS <= {sdaS[1:0], sdaIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      shreg   <= '0;
      txShift <= '0;
      rdMode  <= 1'b0;
      gotWord <= 1'b0;
      mastAck <= 1'b0;
      sdaLow  <= 1'b0;
      st      <= '0;
    end else begin
      st <= '0;
      if (startDet) begin
        state  <= S_DEV;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopDet) begin
        state  <= S_IDLE;
        sdaLow <= 1'b0;
      end else begin
        case (state)
          S_DEV: begin
            if (sclRise) begin
              shreg  <= {shreg[6:0], sdaBit};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (shreg[7:1] == devAddr) begin
                sdaLow <= 1'b1;
                rdMode <= shreg[0];
                state  <= S_DEVACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_DEVACK: if (sclFall) begin
            bitCnt  <= '0;
            gotWord <= 1'b0;
            if (rdMode) begin
              sdaLow  <= ~rdByte[7];
              txShift <= {rdByte[6:0], 1'b1};
              state   <= S_SEND;
            end else begin
              sdaLow <= 1'b0;
              state  <= S_RECV;
            end
          end
          S_RECV: begin
            if (sclRise) begin
              shreg  <= {shreg[6:0], sdaBit};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (!gotWord) begin
                st.setPtr <= 1'b1;
                st.data   <= shreg;
                gotWord   <= 1'b1;
                sdaLow    <= 1'b1;
                state     <= S_RECVACK;
              end else if (!wpIn) begin
                st.writeByte <= 1'b1;
                st.data      <= shreg;
                sdaLow       <= 1'b1;
                state        <= S_RECVACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_RECVACK: if (sclFall) begin
            sdaLow <= 1'b0;
            bitCnt <= '0;
            state  <= S_RECV;
          end
          S_SEND: if (sclFall) begin
            if (bitCnt == 4'd7) begin
              sdaLow    <= 1'b0;
              st.incPtr <= 1'b1;
              state     <= S_SENDACK;
            end else begin
              sdaLow  <= ~txShift[7];
              txShift <= {txShift[6:0], 1'b1};
              bitCnt  <= bitCnt + 1'b1;
            end
          end
          S_SENDACK: begin
            if (sclRise) mastAck <= ~sdaBit;
            if (sclFall) begin
              if (mastAck) begin
                sdaLow  <= ~rdByte[7];
                txShift <= {rdByte[6:0], 1'b1};
                bitCnt  <= '0;
                state   <= S_SEND;
              end else begin
                sdaLow <= 1'b0;
                state  <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  addr_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startDet && !stopDet && state == S_DEV && sclFall && bitCnt == 4'd8 && shreg[7:1] != devAddr)
      |=> !sdaLow);

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startDet && !stopDet && state == S_RECV && gotWord && wpIn && sclFall && bitCnt == 4'd8)
      |=> (!sdaLow && !st.writeByte));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (!sdaLow && state == S_IDLE));

endmodule

// File: rtl/spdResponder.sv
module spdResponder
  import spd_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int CSUM_POS  = 63
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapIn,
  input  logic       wpIn,
  output logic       sdaLow
);

  spdStrobe_t st;
  logic [7:0] rdByte;

  spdCtrl ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapIn(strapIn), .wpIn(wpIn), .rdByte(rdByte),
    .st(st), .sdaLow(sdaLow)
  );

  spdStore #(.MEM_BYTES(MEM_BYTES), .CSUM_POS(CSUM_POS)) store (
    .clk(clk), .rstN(rstN), .st(st), .rdByte(rdByte)
  );

endmodule

// File: tb/spdResponder_test.sv
module spdResponder_test;

  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] WADDR = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] RADDR = {4'b1010, STRAP, 1'b1};

  typedef struct { logic [7:0] v; string tag; } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic sdaLow;
  logic sdaLine;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];
  expItem_t expQ[$];
  logic [7:0] gotQ[$];

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaLow;

  spdResponder uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .strapIn(STRAP), .wpIn(wp), .sdaLow(sdaLow)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic waitH(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitH(H); scl = 1'b1; waitH(H);
    sdaM = 1'b0; waitH(H); scl = 1'b0; waitH(H);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitH(H); scl = 1'b1; waitH(H);
    sdaM = 1'b1; waitH(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitH(H); scl = 1'b1; waitH(H); scl = 1'b0;
    end
    sdaM = 1'b1; waitH(H); scl = 1'b1; waitH(H / 2);
    acked = ~sdaLine;
    waitH(H / 2); scl = 1'b0;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit ackIt);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitH(H); scl = 1'b1; waitH(H / 2);
      b[i] = sdaLine;
      waitH(H / 2); scl = 1'b0;
    end
    sdaM = ackIt ? 1'b0 : 1'b1;
    waitH(H); scl = 1'b1; waitH(H); scl = 1'b0;
    waitH(1); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] modelSum();
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 63; i++) s = s + model[i];
    return s;
  endfunction

  task automatic expectByte(input logic [7:0] v, input string tag);
    expItem_t e;
    e.v = v; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Set the pointer, then read n bytes through a repeated START; ack all but the last.
  task automatic readFrom(input logic [7:0] ptr, input int n);
    bit a;
    logic [7:0] b;
    startCond();
    sendByte(WADDR, a); check(a, "R2 write address ack", {7'd0, a}, 8'd1);
    sendByte(ptr, a);   check(a, "R4 word address ack", {7'd0, a}, 8'd1);
    startCond();
    sendByte(RADDR, a); check(a, "R2 read address ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recvByte(b, k < n - 1);
      gotQ.push_back(b);
    end
    stopCond();
    check(!sdaLow, "R6 line released after not-acknowledge", {7'd0, sdaLow}, 8'd0);
  endtask

  task automatic writeAt(input logic [7:0] ptr, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input int n, input bit expAck, input string tag);
    bit a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    startCond();
    sendByte(WADDR, a); check(a, "R2 write address ack", {7'd0, a}, 8'd1);
    sendByte(ptr, a);   check(a, "R4/R8 word address ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      sendByte(d[k], a);
      check(a == expAck, tag, {7'd0, a}, {7'd0, expAck});
      if (expAck) model[8'(ptr + k)] = d[k];
      if (!a) break;
    end
    stopCond();
    waitH(4);
  endtask

  // Scoreboard monitor: compares each byte the master received against the expected queue.
  initial begin
    forever begin
      wait (gotQ.size() > 0);
      begin
        logic [7:0] g;
        expItem_t e;
        g = gotQ.pop_front();
        if (expQ.size() == 0) check(1'b0, "scoreboard unexpected byte", g, 8'h00);
        else begin
          e = expQ.pop_front();
          check(g == e.v, e.tag, g, e.v);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[0] = 8'h80; model[1] = 8'h08; model[2] = 8'h04; model[63] = 8'h8C;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitH(4);
    check(!sdaLow, "R1 line released after reset", {7'd0, sdaLow}, 8'd0);

    // R1, R5, R6: reset contents via random then sequential read
    expectByte(8'h80, "R1 R5 byte0"); expectByte(8'h08, "R1 R6 byte1");
    expectByte(8'h04, "R1 R6 byte2"); expectByte(8'h00, "R6 byte3");
    readFrom(8'd0, 4);
    expectByte(8'h8C, "R1 checksum byte after reset");
    readFrom(8'd63, 1);

    // R3: wrong strap code is ignored
    startCond();
    sendByte({4'b1010, 3'b000, 1'b0}, a);
    check(!a, "R3 mismatched address not acked", {7'd0, a}, 8'd0);
    sendByte(8'h00, a);
    check(!a, "R3 ignored until next START", {7'd0, a}, 8'd0);
    stopCond();
    check(!sdaLow, "R10 idle after STOP", {7'd0, sdaLow}, 8'd0);

    // R4, R9: multi-byte store then readback and checksum
    writeAt(8'd10, 8'h11, 8'h22, 8'h33, 3, 1'b1, "R4 data byte ack");
    expectByte(8'h11, "R4 byte10"); expectByte(8'h22, "R4 byte11"); expectByte(8'h33, "R4 byte12");
    readFrom(8'd10, 3);
    expectByte(modelSum(), "R9 checksum after store");
    readFrom(8'd63, 1);

    // R7: store wraps from 255 to 0, covered byte 0 changes checksum
    writeAt(8'hFE, 8'h5A, 8'h6B, 8'h7C, 3, 1'b1, "R7 wrapping store ack");
    expectByte(8'h5A, "R7 byte254"); expectByte(8'h6B, "R7 byte255"); expectByte(8'h7C, "R7 byte0 after wrap");
    readFrom(8'hFE, 3);
    expectByte(modelSum(), "R9 checksum after wrapped store");
    readFrom(8'd63, 1);

    // R8: write protect
    wp = 1'b1;
    writeAt(8'd20, 8'hEE, 8'h00, 8'h00, 1, 1'b0, "R8 protected data not acked");
    wp = 1'b0;
    expectByte(8'h00, "R8 byte20 unchanged");
    expectByte(modelSum(), "R8 R9 checksum unchanged");
    readFrom(8'd20, 1);
    readFrom(8'd63, 1);

    waitH(20);
    check(expQ.size() == 0, "scoreboard drained", 8'(expQ.size()), 8'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule